// File: doc/BRIEF.md
# Interrupt Request Conditioning and Pending Latch

This block takes up to 32 external interrupt lines and turns each one into a latched request for the core. Each line first passes through a two-flop synchroniser. After that, the line is treated as level-sensitive or edge-sensitive, chosen per line. In edge mode, a pulse extender stretches short pulses before the rising-edge detector sees them. A detected request sets a pending bit. The pending bit stays set until one of two things happens: the core acknowledges entry to that line's handler, or software cancels the request.

Software reaches the block through a small register port. Enables and pending bits each have a separate write-one-to-set register and write-one-to-clear register, so a single write never disturbs the other lines. A per-line mode register selects level or edge detection. A read-only active vector records which handlers have been entered. A bit is set on acknowledge and cleared on the matching exception-return pulse. The output vector is pending AND enable, ready for a downstream priority arbiter.

Top module: `irq_pend_bank`

## Requirements
- R1: After reset, enable, pending, active and mode are all zero, and `req_o` is zero.
- R2: Level mode (mode bit 0): a high level on `irq_i[x]` sets pending[x]. The bit is visible on `req_o` after the third rising clock edge that samples the high input, and not after the second. While the line stays high, pending is set again on every cycle.
- R3: A pending bit stays set after its input line drops. It falls only on an acknowledge or a software clear.
- R4: Edge mode (mode bit 1): only a rising transition of the synchronised line sets pending. A line held high after acknowledge does not raise the request again. A new rising transition does.
- R5: In edge mode, the synchronised line is stretched for at least `EXT_CYC` cycles. With `EXT_CYC`=2, a high/low/high pattern of single cycles is one event, not two.
- R6: Writing address 2 sets every pending bit whose data bit is 1. Writing address 3 clears them. Zero data bits have no effect. A cleared request never appears on `req_o`.
- R7: Writing address 0 sets enable bits, and writing address 1 clears them, for the data bits that are 1. Bit x of the write data addresses source x. Reading address 0 or 1 returns enable, and `req_o` equals pending AND enable.
- R8: An acknowledge for id x with x < `N_SRC` clears pending[x] and sets active[x]. A hardware or software set in the same cycle wins over the clear. An acknowledge with id ≥ `N_SRC` changes nothing.
- R9: An exception-return pulse for id x clears active[x]. Reading address 4 returns active, and writes to address 4 have no effect.
- R10: Address 5 is the read/write mode register. Reading address 2 or 3 returns pending. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Raw interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | N_SRC | Write data, bit x for source x |
| reg_rdata_o | output | N_SRC | Read data for `reg_addr_i` |
| ack_valid_i | input | 1 | Core enters a handler |
| ack_id_i | input | IDW | Source number being entered |
| eret_i | input | 1 | Exception-return pulse |
| eret_id_i | input | IDW | Source number returning |
| req_o | output | N_SRC | Pending and enabled requests |

## Verification
The bench builds the block with `N_SRC`=6 and `EXT_CYC`=2. With six sources the id field is three bits wide, so ids 6 and 7 are legal encodings that name no source. This lets the bench exercise the out-of-range acknowledge and exception-return cases. With `EXT_CYC`=2, a one-cycle gap between two pulses is exactly covered by the extender, which exposes the merged-edge behaviour. The bench also acknowledges inside that gap, so a missing extender would show up as a re-raised pending bit.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [2:0] {
    RA_EN_SET = 3'd0,
    RA_EN_CLR = 3'd1,
    RA_PD_SET = 3'd2,
    RA_PD_CLR = 3'd3,
    RA_ACTIVE = 3'd4,
    RA_MODE   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_in_stage.sv
module irq_in_stage #(
  parameter int EXT_CYC = 2,
  localparam int CW = $clog2(EXT_CYC) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_mode_i,
  output logic hit_o
);
  logic s1_q, s2_q, prv_q, stretched, rise;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      prv_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= line_i;
      s2_q  <= s1_q;
      prv_q <= stretched;
      // hold tail for EXT_CYC-1 cycles after the synced line falls
      if (s2_q)              cnt_q <= CW'(EXT_CYC - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign stretched = s2_q | (cnt_q != '0);
  assign rise      = stretched & ~prv_q;
  assign hit_o     = edge_mode_i ? rise : s2_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_pend_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] act_i,
  input  logic [N_SRC-1:0] mode_i,
  output logic [N_SRC-1:0] en_set_o,
  output logic [N_SRC-1:0] en_clr_o,
  output logic [N_SRC-1:0] pd_set_o,
  output logic [N_SRC-1:0] pd_clr_o,
  output logic             mode_we_o,
  output logic [N_SRC-1:0] rdata_o
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(addr_i);

  always_comb begin
    en_set_o  = '0;
    en_clr_o  = '0;
    pd_set_o  = '0;
    pd_clr_o  = '0;
    mode_we_o = 1'b0;
    if (we_i) begin
      case (ra)
        RA_EN_SET: en_set_o  = wdata_i;
        RA_EN_CLR: en_clr_o  = wdata_i;
        RA_PD_SET: pd_set_o  = wdata_i;
        RA_PD_CLR: pd_clr_o  = wdata_i;
        RA_MODE:   mode_we_o = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (ra)
      RA_EN_SET, RA_EN_CLR: rdata_o = en_i;
      RA_PD_SET, RA_PD_CLR: rdata_o = pend_i;
      RA_ACTIVE:            rdata_o = act_i;
      RA_MODE:              rdata_o = mode_i;
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int N_SRC = 32,
  parameter int IDW   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hit_i,
  input  logic [N_SRC-1:0] en_set_i,
  input  logic [N_SRC-1:0] en_clr_i,
  input  logic [N_SRC-1:0] pd_set_i,
  input  logic [N_SRC-1:0] pd_clr_i,
  input  logic             mode_we_i,
  input  logic [N_SRC-1:0] mode_wdata_i,
  input  logic             ack_valid_i,
  input  logic [IDW-1:0]   ack_id_i,
  input  logic             eret_i,
  input  logic [IDW-1:0]   eret_id_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] act_o,
  output logic [N_SRC-1:0] mode_o
);
  logic [N_SRC-1:0] ack_hot, eret_hot;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      ack_hot[i]  = ack_valid_i && (ack_id_i == IDW'(i));
      eret_hot[i] = eret_i && (eret_id_i == IDW'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pend_o <= '0;
      act_o  <= '0;
      mode_o <= '0;
    end else begin
      en_o   <= (en_o & ~en_clr_i) | en_set_i;
      // any set beats any clear
      pend_o <= (pend_o & ~(pd_clr_i | ack_hot)) | hit_i | pd_set_i;
      act_o  <= (act_o & ~eret_hot) | ack_hot;
      if (mode_we_i) mode_o <= mode_wdata_i;
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC   = 32,
  parameter int EXT_CYC = 2,
  localparam int IDW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  input  logic             ack_valid_i,
  input  logic [IDW-1:0]   ack_id_i,
  input  logic             eret_i,
  input  logic [IDW-1:0]   eret_id_i,
  output logic [N_SRC-1:0] req_o
);
  logic [N_SRC-1:0] hit, en_w, pend_w, act_w, mode_w;
  logic [N_SRC-1:0] en_set, en_clr, pd_set, pd_clr;
  logic             mode_we;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_in_stage #(.EXT_CYC(EXT_CYC)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (irq_i[g]),
      .edge_mode_i(mode_w[g]),
      .hit_o      (hit[g])
    );
  end

  irq_reg_port #(.N_SRC(N_SRC)) u_port (
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .en_i     (en_w),
    .pend_i   (pend_w),
    .act_i    (act_w),
    .mode_i   (mode_w),
    .en_set_o (en_set),
    .en_clr_o (en_clr),
    .pd_set_o (pd_set),
    .pd_clr_o (pd_clr),
    .mode_we_o(mode_we),
    .rdata_o  (reg_rdata_o)
  );

  irq_state #(.N_SRC(N_SRC), .IDW(IDW)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .en_set_i    (en_set),
    .en_clr_i    (en_clr),
    .pd_set_i    (pd_set),
    .pd_clr_i    (pd_clr),
    .mode_we_i   (mode_we),
    .mode_wdata_i(reg_wdata_i),
    .ack_valid_i (ack_valid_i),
    .ack_id_i    (ack_id_i),
    .eret_i      (eret_i),
    .eret_id_i   (eret_id_i),
    .en_o        (en_w),
    .pend_o      (pend_w),
    .act_o       (act_w),
    .mode_o      (mode_w)
  );

  assign req_o = pend_w & en_w;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int N_SRC = 32,
  parameter int IDW   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [N_SRC-1:0] reg_wdata_i,
  input logic             ack_valid_i,
  input logic [IDW-1:0]   ack_id_i,
  input logic             eret_i,
  input logic [IDW-1:0]   eret_id_i,
  input logic [N_SRC-1:0] en,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] act
);
  logic [N_SRC-1:0] may_drop;
  always_comb begin
    may_drop = (reg_we_i && reg_addr_i == 3'd3) ? reg_wdata_i : '0;
    for (int i = 0; i < N_SRC; i++)
      if (ack_valid_i && int'(ack_id_i) == i) may_drop[i] = 1'b1;
  end

  assert_en_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0) |=> ((en & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_en_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd1) |=> ((en & $past(reg_wdata_i)) == '0));

  assert_pd_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd2) |=> ((pend & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend) & ~pend & ~$past(may_drop)) == '0));

  assert_ack_act_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && int'(ack_id_i) < N_SRC) |=> act[$past(ack_id_i)]);

  assert_eret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && int'(eret_id_i) < N_SRC && !(ack_valid_i && ack_id_i == eret_id_i))
      |=> !act[$past(eret_id_i)]);

  assert_act_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd4 && !ack_valid_i && !eret_i) |=> $stable(act));
endmodule

bind irq_pend_bank irq_pend_chk #(.N_SRC(N_SRC), .IDW(IDW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .ack_valid_i(ack_valid_i),
  .ack_id_i   (ack_id_i),
  .eret_i     (eret_i),
  .eret_id_i  (eret_id_i),
  .en         (en_w),
  .pend       (pend_w),
  .act        (act_w)
);

// File: tb/tb_irq_pend_bank.sv
module tb_irq_pend_bank;
  localparam int N = 6;
  localparam int EXT = 2;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0, wd = '0;
  logic we = 1'b0, ack_v = 1'b0, eret = 1'b0;
  logic [2:0] addr = '0;
  logic [IW-1:0] ack_id = '0, eret_id = '0;
  logic [N-1:0] rdata, req;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  irq_pend_bank #(.N_SRC(N), .EXT_CYC(EXT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .ack_valid_i(ack_v), .ack_id_i(ack_id),
    .eret_i(eret), .eret_id_i(eret_id), .req_o(req)
  );

  // behavioural reference
  bit m_en[N], m_pd[N], m_act[N], m_mode[N], m_a[N], m_b[N], m_prev[N];
  int m_tail[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_en[i]) begin
        m_en[i] = 0; m_pd[i] = 0; m_act[i] = 0; m_mode[i] = 0;
        m_a[i] = 0; m_b[i] = 0; m_prev[i] = 0; m_tail[i] = 0;
      end
    end else begin
      foreach (m_en[i]) begin
        bit seen, raise, drop;
        seen  = m_b[i] || (m_tail[i] > 0);
        raise = (m_mode[i] ? (seen && !m_prev[i]) : m_b[i])
                || (we && addr == 2 && wd[i]);
        drop  = (ack_v && ack_id == i) || (we && addr == 3 && wd[i]);
        if (raise) m_pd[i] = 1; else if (drop) m_pd[i] = 0;
        if (we && addr == 0 && wd[i]) m_en[i] = 1;
        if (we && addr == 1 && wd[i]) m_en[i] = 0;
        if (ack_v && ack_id == i) m_act[i] = 1;
        else if (eret && eret_id == i) m_act[i] = 0;
        if (we && addr == 5) m_mode[i] = wd[i];
        m_tail[i] = m_b[i] ? EXT - 1 : (m_tail[i] > 0 ? m_tail[i] - 1 : 0);
        m_prev[i] = seen;
        m_b[i] = m_a[i];
        m_a[i] = irq[i];
      end
    end
  end

  function automatic logic [N-1:0] m_read(input logic [2:0] a);
    logic [N-1:0] v = '0;
    foreach (m_en[i])
      case (a)
        0, 1: v[i] = m_en[i];
        2, 3: v[i] = m_pd[i];
        4:    v[i] = m_act[i];
        5:    v[i] = m_mode[i];
        default: v[i] = 0;
      endcase
    return v;
  endfunction

  function automatic logic [N-1:0] m_req();
    logic [N-1:0] v;
    foreach (m_en[i]) v[i] = m_en[i] & m_pd[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    nchk++;
    if (act_v !== exp_v) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  // cycle-by-cycle compare against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R7 req_o vs model", 32'(req), 32'(m_req()));
      chk("R10 rdata vs model", 32'(rdata), 32'(m_read(addr)));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1; addr = a; wd = d;
    @(negedge clk); we = 0; wd = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic ack(input logic [IW-1:0] id);
    @(negedge clk); ack_v = 1; ack_id = id;
    @(negedge clk); ack_v = 0;
  endtask

  task automatic ret(input logic [IW-1:0] id);
    @(negedge clk); eret = 1; eret_id = id;
    @(negedge clk); eret = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] v, snap;
    cyc(3);
    rst_n = 1;
    // R1
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset register value", 32'(v), 0);
    end
    chk("R1 reset req_o", 32'(req), 0);

    // R7 enable set/clear
    wr(0, 6'b101011); rd(0, v); chk("R7 enable set", 32'(v), 32'b101011);
    wr(1, 6'b000011); rd(1, v); chk("R7 enable clear", 32'(v), 32'b101000);
    wr(0, 6'b000000); rd(0, v); chk("R7 zero write no effect", 32'(v), 32'b101000);

    // R6 software pending
    wr(2, 6'b001000); @(negedge clk); chk("R6 sw set reaches req_o", 32'(req), 32'b001000);
    wr(3, 6'b001000); @(negedge clk); chk("R6 sw clear removes request", 32'(req), 0);
    wr(2, 6'b000001); rd(2, v); chk("R6 pending on disabled src", 32'(v), 32'b000001);
    chk("R7 disabled src not on req_o", 32'(req), 0);
    wr(2, 6'b000000); rd(3, v); chk("R6 zero set no effect", 32'(v), 32'b000001);
    wr(3, 6'b000001);
    wr(0, 6'b111111);

    // R2 level latency
    @(negedge clk); irq[1] = 1;
    @(negedge clk);
    @(negedge clk); chk("R2 not yet after two edges", 32'(req[1]), 0);
    @(negedge clk); chk("R2 level raises req", 32'(req[1]), 1);
    irq[1] = 0; cyc(5);
    chk("R3 pending held after line drops", 32'(req[1]), 1);
    ack(1); rd(2, v); chk("R8 ack clears pending", 32'(v[1]), 0);
    rd(4, v); chk("R8 ack sets active", 32'(v[1]), 1);

    // R2 level held across ack
    irq[2] = 1; cyc(4); ack(2); cyc(1);
    chk("R2 level held re-pends", 32'(req[2]), 1);
    irq[2] = 0; cyc(4); ack(2); cyc(1);
    chk("R8 level released then ack", 32'(req[2]), 0);

    // R4 edge mode on src4
    wr(5, 6'b010000); rd(5, v); chk("R10 mode readback", 32'(v), 32'b010000);
    irq[4] = 1; cyc(4); chk("R4 rising edge pends", 32'(req[4]), 1);
    ack(4); cyc(3); chk("R4 held high no re-pend", 32'(req[4]), 0);
    irq[4] = 0; cyc(4); irq[4] = 1; cyc(4);
    chk("R4 new edge pends", 32'(req[4]), 1);
    ack(4); irq[4] = 0; cyc(6);

    // R5 high/low/high single-cycle pattern, ack in the gap
    @(negedge clk); irq[4] = 1;
    @(negedge clk); irq[4] = 0;
    @(negedge clk); irq[4] = 1;
    @(negedge clk); irq[4] = 0; ack_v = 1; ack_id = 4;
    @(negedge clk); ack_v = 0;
    cyc(5); rd(2, v); chk("R5 merged pulses one event", 32'(v[4]), 0);

    // R8 set wins over ack
    @(negedge clk); we = 1; addr = 2; wd = 6'b000001; ack_v = 1; ack_id = 0;
    @(negedge clk); we = 0; wd = '0; ack_v = 0;
    rd(2, v); chk("R8 set wins over ack", 32'(v[0]), 1);
    snap = v;
    ack(7); rd(2, v); chk("R8 out-of-range ack ignored", 32'(v), 32'(snap));
    rd(4, v); chk("R8 active after acks", 32'(v), 32'b010111);
    wr(3, 6'b000001); @(negedge clk); chk("R6 clear after set", 32'(req), 0);

    // R9 exception return and read-only active
    ret(1); rd(4, v); chk("R9 eret clears active", 32'(v), 32'b010101);
    wr(4, 6'b111111); rd(4, v); chk("R9 active not writable", 32'(v), 32'b010101);
    ret(7); rd(4, v); chk("R9 out-of-range eret ignored", 32'(v), 32'b010101);

    // R10 mode and unused address
    wr(5, 6'b101010); rd(5, v); chk("R10 mode write", 32'(v), 32'b101010);
    rd(6, v); chk("R10 unused address reads zero", 32'(v), 0);
    cyc(3);
    finish_run();
  end
endmodule